// File: doc/BRIEF.md
# Converter Master Serial Readout Controller

This block models the digital output side of a sampling converter that generates its own serial clock. A single-cycle start pulse begins a conversion, which holds a busy flag for a fixed number of cycles. The converted value is taken from a test input word when the start is accepted. At the end of the conversion it becomes the stored result. The result is shifted out most significant bit first over exactly 16 generated clock pulses. A frame signal marks the cycles in which serial data is valid.

A mode input picks one of two timings. In after-conversion mode the fresh result is sent once busy drops; this is the preferred mode, because acquisition lasts longer than conversion. In during-conversion mode the previous result is sent while the new conversion is busy. Two inputs invert the generated clock and the frame signal. Serial output runs only when serial operation is selected and the internal-clock (master) option is chosen. Otherwise the serial pins sit at their idle levels while conversions still run.

The controller is a four-state machine:
- **ST_IDLE** goes to **ST_CONV_SEND** when a start is accepted in during-conversion mode with serial output enabled. It goes to **ST_CONV** on any other accepted start.
- **ST_CONV** goes to **ST_SEND** at conversion end in after-conversion mode with serial output enabled. At conversion end in any other case it goes to ST_IDLE.
- **ST_CONV_SEND** goes to ST_IDLE when conversion end and the last bit coincide. It goes to ST_SEND when only the conversion ends, and to ST_CONV when only the last bit ends.
- **ST_SEND** goes to ST_IDLE after the last bit.

Top module: `ser_master_readout`

## Requirements
- R1: After reset `busy` and `done` are 0, `sdata` is 0, `sclk` equals `inv_sclk`, and `frame` equals `inv_frame`.
- R2: A start accepted in ST_IDLE raises `busy` in the next cycle for exactly BUSY_CYCLES cycles. A start that arrives while busy or while a frame is running is ignored, along with its data word.
- R3: A frame lasts 16×CLK_DIV cycles. Each bit lasts CLK_DIV cycles. The internal clock is low for the first quarter of a bit, high for the middle half and low for the last quarter, which gives exactly 16 pulses.
- R4: `sdata` changes only at bit boundaries, midway between a falling and the next rising edge of the internal clock. Bits are sent most significant bit first, so bit 15 of the word is sent first.
- R5: With `read_prev`=0, the frame starts in the first cycle that `busy` is low. It carries `conv_word` as sampled in the cycle the start was accepted.
- R6: With `read_prev`=1, the frame starts in the same cycle that `busy` rises. It carries the result of the previous conversion, which is 0 when no conversion has completed since reset.
- R7: `sclk` equals the internal clock XOR `inv_sclk`, and `frame` equals the internal frame XOR `inv_frame`, with no added latency.
- R8: `sdata` is 0 outside a frame. `done` is high for exactly one cycle, the cycle right after the last bit cycle.
- R9: When `serial_en`=0 or `clk_sel_ext`=1, no frame is shown: `sclk`, `frame` and `sdata` keep their R1 idle levels and `done` stays 0. Conversions and `busy` still run, and the result is still stored.
- R10: The read mode is taken when a start is accepted. Changes on `read_prev` during a conversion do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_en | input | 1 | 1 selects serial operation |
| clk_sel_ext | input | 1 | 0 selects the internally generated (master) clock |
| read_prev | input | 1 | 0: send after conversion; 1: send previous result during conversion |
| inv_sclk | input | 1 | Inverts the serial clock |
| inv_frame | input | 1 | Inverts the frame signal |
| conv_start | input | 1 | Single-cycle start-of-conversion pulse |
| conv_word | input | 16 | Test value standing in for the conversion result |
| busy | output | 1 | Conversion in progress |
| sclk | output | 1 | Generated serial clock |
| frame | output | 1 | Serial data valid marker |
| sdata | output | 1 | Serial data, MSB first |
| done | output | 1 | One-cycle pulse after the 16th bit |

## Verification
The start is driven on a falling edge and taken at the next rising edge. Counting from the falling edge that follows:
- `busy` is due for cycles 0 to BUSY_CYCLES−1.
- A during-conversion frame covers cycles 0 to 16×CLK_DIV−1.
- An after-conversion frame begins at cycle BUSY_CYCLES.
- `done` is due in the cycle after the last frame cycle.

The bench samples every output on each falling edge against a per-cycle expectation computed from these offsets. Within a frame it derives the bit index and the clock phase from the cycle count. Inside each conversion it also drives a competing start and toggles the mode, so that R2 and R10 are checked in the same cycles.

// File: rtl/ser_readout_pkg.sv
package ser_readout_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_CONV      = 2'd1,
        ST_CONV_SEND = 2'd2,
        ST_SEND      = 2'd3
    } rd_state_t;
endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int BUSY_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic conv_end
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= '0;
        else if (launch)
            remain_q <= LOAD;
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign busy     = (remain_q != '0);
    assign conv_end = (remain_q == CW'(1));

    // R2: a launch always yields a full busy window
    p_busy_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && remain_q == LOAD));
    // R2: busy never restarts mid-window
    p_busy_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !launch) |=> (remain_q == $past(remain_q) - 1'b1));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int WORD_W  = 16,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    output logic              active,
    output logic              sclk_int,
    output logic              sdata_int,
    output logic              tx_last,
    output logic              done_pulse
);
    localparam int PH_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLK_DIV - 1);
    localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(CLK_DIV / 4);
    localparam logic [PH_W-1:0]  PH_FALL  = PH_W'(CLK_DIV / 4 + CLK_DIV / 2);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    logic [PH_W-1:0]   phase_q;
    logic [BIT_W-1:0]  bitn_q;
    logic [WORD_W-1:0] shreg_q;
    logic              active_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phase_q  <= '0;
            bitn_q   <= '0;
            shreg_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= tx_last;
            if (load) begin
                active_q <= 1'b1;
                phase_q  <= '0;
                bitn_q   <= '0;
                shreg_q  <= load_word;
            end else if (active_q) begin
                if (phase_q == PH_LAST) begin
                    phase_q <= '0;
                    shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                    if (bitn_q == BIT_LAST)
                        active_q <= 1'b0;
                    else
                        bitn_q <= bitn_q + 1'b1;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end
        end
    end

    assign active     = active_q;
    assign sclk_int   = active_q && (phase_q >= PH_RISE) && (phase_q < PH_FALL);
    assign sdata_int  = active_q ? shreg_q[WORD_W-1] : 1'b0;
    assign tx_last    = active_q && (phase_q == PH_LAST) && (bitn_q == BIT_LAST);
    assign done_pulse = done_q;

    // R4: data moves only while the clock is low on both sides of the change
    p_data_midway_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && $changed(sdata_int)) |-> (!sclk_int && !$past(sclk_int)));
    // R8: done lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R8: data low outside a frame
    p_data_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !sdata_int);
    // R3: a new frame starts at phase zero
    p_frame_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (active_q && phase_q == '0 && bitn_q == '0 && !sclk_int));
endmodule

// File: rtl/ser_master_readout.sv
module ser_master_readout
    import ser_readout_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int BUSY_CYCLES = 24,
    parameter int CLK_DIV     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_en,
    input  logic              clk_sel_ext,
    input  logic              read_prev,
    input  logic              inv_sclk,
    input  logic              inv_frame,
    input  logic              conv_start,
    input  logic [WORD_W-1:0] conv_word,
    output logic              busy,
    output logic              sclk,
    output logic              frame,
    output logic              sdata,
    output logic              done
);
    rd_state_t         state_q, state_d;
    logic              serial_ok;
    logic              accept, load, conv_end, tx_last;
    logic              active, sclk_int, sdata_int, done_int;
    logic [WORD_W-1:0] load_word;
    logic [WORD_W-1:0] sample_q, result_q;
    logic              mode_q;

    assign serial_ok = serial_en && !clk_sel_ext;

    conv_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (accept),
        .busy     (busy),
        .conv_end (conv_end)
    );

    frame_shifter #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_word  (load_word),
        .active     (active),
        .sclk_int   (sclk_int),
        .sdata_int  (sdata_int),
        .tx_last    (tx_last),
        .done_pulse (done_int)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            result_q <= '0;
            mode_q   <= 1'b0;
        end else begin
            if (accept) begin
                sample_q <= conv_word;
                mode_q   <= read_prev;
            end
            if (conv_end)
                result_q <= sample_q;
        end
    end

    always_comb begin
        state_d   = state_q;
        accept    = 1'b0;
        load      = 1'b0;
        load_word = sample_q;
        unique case (state_q)
            ST_IDLE: begin
                if (conv_start) begin
                    accept = 1'b1;
                    if (read_prev && serial_ok) begin
                        load      = 1'b1;
                        load_word = result_q;
                        state_d   = ST_CONV_SEND;
                    end else begin
                        state_d = ST_CONV;
                    end
                end
            end
            ST_CONV: begin
                if (conv_end) begin
                    if (!mode_q && serial_ok) begin
                        load      = 1'b1;
                        load_word = sample_q;
                        state_d   = ST_SEND;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_CONV_SEND: begin
                if (conv_end && tx_last)
                    state_d = ST_IDLE;
                else if (conv_end)
                    state_d = ST_SEND;
                else if (tx_last)
                    state_d = ST_CONV;
            end
            ST_SEND: begin
                if (tx_last)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign sclk  = (serial_ok && sclk_int) ^ inv_sclk;
    assign frame = (serial_ok && active) ^ inv_frame;
    assign sdata = serial_ok && sdata_int;
    assign done  = serial_ok && done_int;

    // R2: a start outside idle leaves the captured word untouched
    p_ignore_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && conv_start) |=> $stable(sample_q));
    // R5: the after-conversion send never overlaps busy
    p_send_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |-> !busy);
    // R10: the mode latched at the start holds for the whole conversion
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(mode_q) || $past(accept));
    // R6: the during-conversion send begins together with busy
    p_send_with_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV_SEND) |-> (busy && active));
endmodule

// File: tb/sim_ser_master_readout.sv
module sim_ser_master_readout;
    localparam int W    = 16;
    localparam int BUSY = 24;
    localparam int DIV  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic serial_en = 1'b1, clk_sel_ext = 1'b0, read_prev = 1'b0;
    logic inv_sclk = 1'b0, inv_frame = 1'b0, conv_start = 1'b0;
    logic [W-1:0] conv_word = '0;
    logic busy, sclk, frame, sdata, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [W-1:0] prev_model = '0;

    always #2 clk = ~clk;

    ser_master_readout #(.WORD_W(W), .BUSY_CYCLES(BUSY), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .serial_en(serial_en), .clk_sel_ext(clk_sel_ext),
        .read_prev(read_prev), .inv_sclk(inv_sclk), .inv_frame(inv_frame),
        .conv_start(conv_start), .conv_word(conv_word),
        .busy(busy), .sclk(sclk), .frame(frame), .sdata(sdata), .done(done)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input int k);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, k, act, exp);
        end
    endtask

    function automatic logic exp_clk_phase(input int ph);
        return (ph >= DIV / 4) && (ph < DIV / 4 + DIV / 2);
    endfunction

    task automatic run_conv(input logic mode, input logic [W-1:0] w, input logic en,
                            input logic ext, input logic is, input logic ifr);
        logic ok;
        int s, last;
        logic [W-1:0] txw;
        serial_en = en; clk_sel_ext = ext; inv_sclk = is; inv_frame = ifr;
        read_prev = mode; conv_word = w; conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        conv_word  = ~w;
        ok   = en && !ext;
        s    = mode ? 0 : BUSY;
        last = s + W * DIV;
        txw  = mode ? prev_model : w;
        for (int k = 0; k <= last; k++) begin
            logic in_tx, ci, de;
            int ph, bi;
            in_tx = ok && (k >= s) && (k < last);
            ph = in_tx ? (k - s) % DIV : 0;
            bi = in_tx ? (k - s) / DIV : 0;
            ci = in_tx && exp_clk_phase(ph);
            de = in_tx ? txw[W-1-bi] : 1'b0;
            chk("R2 busy", busy, k < BUSY, k);
            if (ok) begin
                chk("R3 sclk", sclk, ci ^ is, k);
                chk("R7 R10 frame", frame, in_tx ^ ifr, k);
                chk(mode ? "R6 R4 sdata" : "R5 R4 sdata", sdata, de, k);
                chk("R8 done", done, k == last, k);
            end else begin
                chk("R9 sclk", sclk, is, k);
                chk("R9 frame", frame, ifr, k);
                chk("R9 sdata", sdata, 1'b0, k);
                chk("R9 done", done, 1'b0, k);
            end
            if (k == 3) begin
                conv_start = 1'b1;
                conv_word  = W'($urandom);
                read_prev  = ~mode;
            end
            if (k == 4) conv_start = 1'b0;
            @(negedge clk);
        end
        prev_model = w;
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 1'b0, 0);
        chk("R1 sclk", sclk, 1'b0, 0);
        chk("R1 frame", frame, 1'b0, 0);
        chk("R1 sdata", sdata, 1'b0, 0);
        chk("R1 done", done, 1'b0, 0);
        inv_sclk = 1'b1; inv_frame = 1'b1;
        #1;
        chk("R1 R7 sclk idle inverted", sclk, 1'b1, 0);
        chk("R1 R7 frame idle inverted", frame, 1'b1, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: first during-conversion frame after reset carries zero
        run_conv(1'b1, 16'hA5C3, 1'b1, 1'b0, 1'b0, 1'b0);
        // R5: fresh result after busy
        run_conv(1'b0, 16'h8001, 1'b1, 1'b0, 1'b0, 1'b0);
        // R6: previous result during conversion
        run_conv(1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0);
        // R7: both inversions
        run_conv(1'b0, 16'h7FFE, 1'b1, 1'b0, 1'b1, 1'b1);
        // R9: serial disabled, then external clock selected
        run_conv(1'b0, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1);
        run_conv(1'b1, 16'h4321, 1'b1, 1'b1, 1'b1, 1'b0);
        // R6: result stored while disabled is sent next
        run_conv(1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int n = 0; n < 24; n++) begin
            logic m, e, x;
            m = 1'($urandom % 2);
            e = ($urandom % 8) != 0;
            x = ($urandom % 8) == 0;
            run_conv(m, W'($urandom), e, x, 1'($urandom % 2), 1'($urandom % 2));
            repeat ($urandom % 3) @(negedge clk);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule